// File: doc/BRIEF.md
# Wide Fixed-Point to Double Converter

The block takes one very wide signed fixed-point word and turns it into an IEEE 754 double-precision value. The word is meant to hold an exact sum. The converter is used only once, on the final result. Bit 0 of the word is the sign. Bits 1 through 2100 hold an unsigned magnitude, and bit position 1076 carries the weight 2^0. The converter searches the magnitude for its most significant set bit and derives the exponent from that position. It keeps the next 52 bits as the fraction and throws away everything below them by truncation toward zero. A separate flag reports whether any discarded bit was set.

Three word patterns have fixed meanings. A magnitude of zero with the sign bit set is not a real number. A magnitude of all ones is infinity, with its sign taken from bit 0. A magnitude large enough to need the reserved exponent code saturates to infinity.

Operands arrive over a valid/ready handshake. Results leave over a valid/ready handshake and are held until they are taken. The leading-one search is split across pipeline stages, so the latency is a fixed 4 clocks. The pipeline advances as a unit whenever the output register is empty or is being drained.

Top module: `bfx_to_double`

## Requirements
- R1: A word with every bit 0 converts to 0x0000000000000000, with the inexact flag 0.
- R2: A word whose magnitude bits are all 0 and whose bit 0 is 1 converts to the quiet NaN 0x7FF8000000000000, with the inexact flag 0.
- R3: A word whose magnitude bits 2100..1 are all 1 converts to infinity. The result is exponent field 0x7FF, fraction 0, and sign equal to bit 0. The inexact flag is 0.
- R4: If the highest set magnitude position P lies in 54..2099, the result is normal. The exponent field (bits 62:52) is P-53. The fraction (bits 51:0) is word positions P-1 down to P-52, most significant first. Result bit 63 equals word bit 0.
- R5: If no magnitude bit above position 53 is set and some magnitude bit is set, the exponent field is 0. The fraction is word positions 53 down to 2.
- R6: Magnitude bits below the fraction window do not change the result, because the result is truncated toward zero. The inexact flag is 1 exactly when at least one of those bits is 1. For example, positions 100 and 10 together give exponent field 47, fraction 0 and inexact 1.
- R7: If P is 2100 and the magnitude is not all ones, the result is signed infinity with the inexact flag 1.
- R8: While out_valid is 1 and out_ready is 0:
  - out_data and out_inexact hold their values;
  - out_valid stays 1;
  - in_ready is 0.
- R9: Results leave in the order the operands were accepted, one result per operand. With out_ready held at 1, out_valid rises after the 4th rising edge, counting the edge that accepts the operand.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Operand is taken on this edge when in_valid is 1 |
| in_word | input | 2101 | Bit 0 sign, bits 2100..1 magnitude, position 1076 = 2^0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | 64 | IEEE 754 double result |
| out_inexact | output | 1 | 1 when nonzero bits were discarded |

## Verification
The bench targets the corner cases that each separate a correct design from a plausible wrong one:
- **Normal/denormal border.** Positions 54 and 53 sit on either side of it. A converter that is off by one there would give the smallest normal exponent 0, or would shift denormal fractions by one place.
- **Fraction window edges.** Positions 100 with 48, and 100 with 10, sit on either side of the window's edge. A sticky flag that covers the wrong range would flag an exact value or miss a lost bit.
- **Lowest position.** Position 1 on its own must give a zero result that is still flagged inexact.
- **Top position and all-ones pattern.** Position 2100 on its own must saturate to infinity. A magnitude of all ones must give infinity that is not flagged. A design that mixed up the two would flag or miss inexactness on infinity.
- **Back-pressure.** Random back-pressure checks that a stalled result never changes and that no operand slips in while the output is blocked.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int EXP_W     = 11;
  localparam int FRAC_W    = 52;
  localparam int EXP_MAX   = (1 << EXP_W) - 1;
  localparam int IEEE_BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [63:0] QNAN_BITS = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } dbl_t;

  // Signed infinity in double format.
  function automatic dbl_t inf_of(input logic s);
    dbl_t r;
    r.sign = s;
    r.expo = '1;
    r.frac = '0;
    return r;
  endfunction

  // Biased exponent for a leading magnitude index; den_top is the index of the
  // implied bit of the smallest normal value.
  function automatic int biased_exp(input int lead, input int den_top);
    return (lead < den_top) ? 0 : lead - (den_top - 1);
  endfunction
endpackage

// File: rtl/bfx_seg_scan.sv
module bfx_seg_scan #(
  parameter int SEG_W = 64,
  parameter int NSEG  = 33,
  parameter int IDX_W = 6
) (
  input  logic [NSEG*SEG_W-1:0]      vec,
  output logic [NSEG-1:0]            seg_nz,
  output logic [NSEG-1:0][IDX_W-1:0] seg_top
);
  // Highest set index inside one segment (0 when empty).
  function automatic logic [IDX_W-1:0] top_one(input logic [SEG_W-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < SEG_W; i++) begin
      if (s[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_nz[g]  = |vec[g*SEG_W +: SEG_W];
    assign seg_top[g] = top_one(vec[g*SEG_W +: SEG_W]);
  end
endmodule

// File: rtl/bfx_seg_pick.sv
module bfx_seg_pick #(
  parameter int SEG_W  = 64,
  parameter int NSEG   = 33,
  parameter int IDX_W  = 6,
  parameter int LEAD_W = 12
) (
  input  logic [NSEG-1:0]            seg_nz,
  input  logic [NSEG-1:0][IDX_W-1:0] seg_top,
  output logic                       found,
  output logic [LEAD_W-1:0]          lead
);
  // Later (higher) segments override lower ones.
  always_comb begin
    found = 1'b0;
    lead  = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_nz[s]) begin
        found = 1'b1;
        lead  = LEAD_W'(s * SEG_W) + LEAD_W'(seg_top[s]);
      end
    end
  end
endmodule

// File: rtl/bfx_pack.sv
module bfx_pack
  import bfx_pkg::*;
#(
  parameter int MAG_W   = 2100,
  parameter int LEAD_W  = 12,
  parameter int DEN_TOP = 53
) (
  input  logic [MAG_W:0]    word,
  input  logic              found,
  input  logic              all_ones,
  input  logic [LEAD_W-1:0] lead,
  output logic [63:0]       dbl,
  output logic              inexact
);
  localparam int LOW_W = MAG_W - 1 - FRAC_W;

  logic [MAG_W-1:0]  mag;
  logic [MAG_W-1:0]  aligned;
  logic [LEAD_W-1:0] anchor;
  logic              is_den;
  int                bexp;
  dbl_t              r;

  assign mag = word[MAG_W:1];

  always_comb begin
    is_den  = (lead < LEAD_W'(DEN_TOP));
    anchor  = is_den ? LEAD_W'(DEN_TOP) : lead;
    aligned = mag << (MAG_W - 1 - int'(anchor));
    bexp    = biased_exp(int'(lead), DEN_TOP);
    inexact = 1'b0;
    r       = '0;
    if (!found) begin
      if (word[0]) r = QNAN_BITS;
    end else if (all_ones) begin
      r = inf_of(word[0]);
    end else if (bexp >= EXP_MAX) begin
      r       = inf_of(word[0]);
      inexact = 1'b1;
    end else begin
      r.sign  = word[0];
      r.expo  = EXP_W'(bexp);
      r.frac  = aligned[MAG_W-2 -: FRAC_W];
      inexact = |aligned[LOW_W-1:0];
    end
    dbl = r;
  end
endmodule

// File: rtl/bfx_to_double.sv
module bfx_to_double
  import bfx_pkg::*;
#(
  parameter int MAG_W  = 2100,
  parameter int ORIGIN = 1076,
  parameter int SEG_W  = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [MAG_W:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [63:0]  out_data,
  output logic         out_inexact
);
  localparam int NSEG    = (MAG_W + SEG_W - 1) / SEG_W;
  localparam int PAD_W   = NSEG * SEG_W;
  localparam int IDX_W   = $clog2(SEG_W);
  localparam int LEAD_W  = $clog2(PAD_W);
  localparam int DEN_TOP = ORIGIN - IEEE_BIAS;

  // stage A: captured operand
  logic           a_valid;
  logic [MAG_W:0] a_word;
  // stage B: per-segment search results
  logic           b_valid;
  logic [MAG_W:0] b_word;
  logic           b_ones;
  logic [NSEG-1:0]            b_nz;
  logic [NSEG-1:0][IDX_W-1:0] b_top;
  // stage C: global leading index
  logic              c_valid;
  logic [MAG_W:0]    c_word;
  logic              c_found;
  logic              c_ones;
  logic [LEAD_W-1:0] c_lead;

  // named internal events
  logic                       pipe_adv;
  logic [PAD_W-1:0]           a_mag_pad;
  logic [NSEG-1:0]            scan_nz;
  logic [NSEG-1:0][IDX_W-1:0] scan_top;
  logic                       pick_found;
  logic [LEAD_W-1:0]          pick_lead;
  logic [63:0]                pack_dbl;
  logic                       pack_inexact;

  assign pipe_adv  = !out_valid || out_ready;
  assign in_ready  = pipe_adv;
  assign a_mag_pad = PAD_W'(a_word[MAG_W:1]);

  bfx_seg_scan #(.SEG_W(SEG_W), .NSEG(NSEG), .IDX_W(IDX_W)) u_scan (
    .vec(a_mag_pad), .seg_nz(scan_nz), .seg_top(scan_top)
  );

  bfx_seg_pick #(.SEG_W(SEG_W), .NSEG(NSEG), .IDX_W(IDX_W), .LEAD_W(LEAD_W)) u_pick (
    .seg_nz(b_nz), .seg_top(b_top), .found(pick_found), .lead(pick_lead)
  );

  bfx_pack #(.MAG_W(MAG_W), .LEAD_W(LEAD_W), .DEN_TOP(DEN_TOP)) u_pack (
    .word(c_word), .found(c_found), .all_ones(c_ones), .lead(c_lead),
    .dbl(pack_dbl), .inexact(pack_inexact)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid   <= 1'b0;
      b_valid   <= 1'b0;
      c_valid   <= 1'b0;
      out_valid <= 1'b0;
    end else if (pipe_adv) begin
      a_valid   <= in_valid;
      b_valid   <= a_valid;
      c_valid   <= b_valid;
      out_valid <= c_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (pipe_adv) begin
      a_word      <= in_word;
      b_word      <= a_word;
      b_ones      <= &a_word[MAG_W:1];
      b_nz        <= scan_nz;
      b_top       <= scan_top;
      c_word      <= b_word;
      c_ones      <= b_ones;
      c_found     <= pick_found;
      c_lead      <= pick_lead;
      out_data    <= pack_dbl;
      out_inexact <= pack_inexact;
    end
  end
endmodule

// File: rtl/bfx_to_double_chk.sv
module bfx_to_double_chk #(
  parameter int MAG_W   = 2100,
  parameter int DEN_TOP = 53,
  parameter int LEAD_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_data,
  input logic              out_inexact,
  input logic              c_valid,
  input logic              c_found,
  input logic              c_ones,
  input logic [LEAD_W-1:0] c_lead,
  input logic              pipe_adv
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_inexact));

  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r4_exp_field: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_adv && c_valid && c_found && !c_ones && (int'(c_lead) >= DEN_TOP) && (int'(c_lead) < MAG_W - 1)
    |=> out_data[62:52] == 11'(int'($past(c_lead)) - (DEN_TOP - 1)));

  a_r5_denorm_exp: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_adv && c_valid && c_found && (int'(c_lead) < DEN_TOP)
    |=> out_data[62:52] == 11'h000);

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_adv && c_valid && c_found && !c_ones && (int'(c_lead) == MAG_W - 1)
    |=> out_data[62:0] == {11'h7FF, 52'h0} && out_inexact);

  a_r2_nan_exact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[62:52] == 11'h7FF && out_data[51:0] != 52'h0
    |-> out_data == 64'h7FF8000000000000 && !out_inexact);
endmodule

bind bfx_to_double bfx_to_double_chk #(.MAG_W(MAG_W), .DEN_TOP(DEN_TOP), .LEAD_W(LEAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_inexact(out_inexact), .c_valid(c_valid), .c_found(c_found),
  .c_ones(c_ones), .c_lead(c_lead), .pipe_adv(pipe_adv)
);

// File: tb/bfx_to_double_tb.sv
`timescale 1ns/1ps
module bfx_to_double_tb;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2100:0] in_word = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [63:0]   out_data;
  logic          out_inexact;

  int checks = 0;
  int errors = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  bit          prev_stall = 1'b0;
  logic [63:0] prev_data;
  logic        prev_ix;

  always #5 clk = ~clk;

  bfx_to_double u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_inexact(out_inexact)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  // Behavioural model built directly from the requirements.
  task automatic model(input logic [2100:0] w, output logic [63:0] d, output logic ix, output string tag);
    int p;
    int cnt;
    logic [51:0] f;
    p = 0; cnt = 0; ix = 1'b0; f = '0;
    for (int k = 1; k <= 2100; k++) if (w[k]) begin p = k; cnt++; end
    if (p == 0) begin
      d   = w[0] ? 64'h7FF8000000000000 : 64'h0;
      tag = w[0] ? "R2" : "R1";
    end else if (cnt == 2100) begin
      d = {w[0], 11'h7FF, 52'h0}; tag = "R3";
    end else if (p == 2100) begin
      d = {w[0], 11'h7FF, 52'h0}; ix = 1'b1; tag = "R7";
    end else if (p >= 54) begin
      for (int k = 0; k < 52; k++) f[51-k] = w[p-1-k];
      for (int j = 1; j <= p - 53; j++) if (w[j]) ix = 1'b1;
      d = {w[0], 11'(p - 53), f}; tag = "R4";
    end else begin
      for (int k = 0; k < 52; k++) f[51-k] = w[53-k];
      ix = w[1];
      d = {w[0], 11'h0, f}; tag = "R5";
    end
  endtask

  function automatic logic [2100:0] bits2(input int hi, input int lo, input bit s);
    logic [2100:0] v;
    v = '0;
    if (hi > 0) v[hi] = 1'b1;
    if (lo > 0) v[lo] = 1'b1;
    v[0] = s;
    return v;
  endfunction

  function automatic logic [2100:0] rand_vec(input int top);
    logic [2100:0] v;
    int cut;
    cut = top - int'($urandom_range(0, 70));
    for (int k = 0; k <= 2100; k++) v[k] = 1'($urandom_range(0, 1));
    for (int k = 1; k <= 2100; k++) if (k > top || (k < cut && $urandom_range(0, 1) == 0)) v[k] = 1'b0;
    v[top] = 1'b1;
    return v;
  endfunction

  // Monitor: samples 1 ns after each falling edge.
  always @(negedge clk) begin
    logic [63:0] ed;
    logic        ei;
    string       et;
    logic [64:0] e;
    string       t;
    #1;
    if (rst_n && !done) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_inexact == prev_ix, "R8 hold",
            {out_inexact, out_data}, {prev_ix, prev_data});
      if (out_valid && !out_ready)
        chk(!in_ready, "R8 in_ready", {64'h0, in_ready}, 65'h0);
      if (in_valid && in_ready) begin
        model(in_word, ed, ei, et);
        exp_q.push_back({ei, ed});
        tag_q.push_back(et);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 extra result", {out_inexact, out_data}, 65'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e[63:0] == out_data && e[64] != out_inexact) t = "R6";
          chk({out_inexact, out_data} == e, t, {out_inexact, out_data}, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_ix    = out_inexact;
    end
  end

  // Consumer side.
  always @(negedge clk) begin
    out_ready <= bp_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic send(input logic [2100:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [2100:0] ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R10 out_valid", {64'h0, out_valid}, 65'h0);
    chk(in_ready == 1'b1, "R10 in_ready", {64'h0, in_ready}, 65'h1);

    // R9 latency with 1.0
    send(bits2(1076, 0, 1'b0));
    idle();
    #1;
    chk(out_valid == 1'b0, "R9 latency n1", {64'h0, out_valid}, 65'h0);
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R9 latency n2", {64'h0, out_valid}, 65'h0);
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R9 latency n3", {64'h0, out_valid}, 65'h0);
    @(negedge clk); #2;
    chk(out_valid == 1'b1 && out_data == 64'h3FF0000000000000, "R9 R4 latency n4",
        {out_inexact, out_data}, {1'b0, 64'h3FF0000000000000});

    // Directed corners
    ones = '1;
    send('0);                                   // R1
    send(bits2(0, 0, 1'b1));                    // R2
    ones[0] = 1'b0; send(ones);                 // R3 +inf
    ones[0] = 1'b1; send(ones);                 // R3 -inf
    send(bits2(1076, 1075, 1'b1));              // R4 -1.5
    send(bits2(100, 10, 1'b0));                 // R6 lost bit
    send(bits2(100, 48, 1'b0));                 // R6 exact edge
    send(bits2(100, 47, 1'b1));                 // R6 first lost
    begin
      logic [2100:0] mx;
      mx = '0;
      for (int k = 2047; k <= 2099; k++) mx[k] = 1'b1;
      send(mx);                                 // R4 largest normal
    end
    send(bits2(2100, 0, 1'b0));                 // R7
    send(bits2(2100, 5, 1'b1));                 // R7 negative
    send(bits2(54, 1, 1'b0));                   // R4 smallest normal + lost bit
    send(bits2(53, 0, 1'b0));                   // R5 top denormal
    send(bits2(2, 0, 1'b1));                    // R5 smallest denormal
    send(bits2(1, 0, 1'b0));                    // R6 only lost bit
    send(bits2(53, 1, 1'b0));                   // R5 + R6
    idle();

    // Random with back-pressure (R8, R9)
    bp_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [2100:0] v;
      case ($urandom_range(0, 3))
        0: v = rand_vec(int'($urandom_range(1, 60)));
        1: v = rand_vec(int'($urandom_range(1000, 1150)));
        default: v = rand_vec(int'($urandom_range(1, 2100)));
      endcase
      send(v);
      if ($urandom_range(0, 4) == 0) idle();
    end
    idle();
    bp_mode = 1'b0;
    for (int n = 0; n < 50 && exp_q.size() != 0; n++) @(negedge clk);
    @(negedge clk); #2;
    chk(exp_q.size() == 0, "R9 all results returned", 65'(exp_q.size()), 65'h0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule